// File: doc/BRIEF.md
# In-Place Exchange Sort Engine

This block holds 2^L words of N bits in a small internal RAM and rearranges them into ascending unsigned order. A host loads the words one at a time while the block is idle. It then raises `start`, waits for `done`, and reads the sorted words back through the same address port.

The sort is a nested exchange sort. An outer index walks each position except the last. An inner index walks every later position. Register A holds the word at the outer position and register B holds the candidate at the inner position. When A is strictly greater than B, the two words trade places. The RAM has a single port with a synchronous read, so each read takes an address cycle and a capture cycle. Each trade takes two write cycles: the outer slot is written first and the inner slot second.

While a sort runs, the host write and read strobes have no effect. `done` stays high until the host lowers `start`. Raising `start` again sorts whatever the RAM currently holds.

Top module: `xsort_engine`

## Requirements
- R1: When reset is released, `done` is 0 and `host_rdata` is 0.
- R2: While the engine is idle, `host_wr` high at a clock edge stores `host_wdata` into the word at `host_addr`.
- R3: While the engine is idle, `host_rd` high with `host_addr` at a clock edge makes `host_rdata` show that word during the following cycle. In any cycle that does not follow such a read, `host_rdata` is 0.
- R4: After a sort, word x holds the x-th smallest of the loaded values, counting from 0 and comparing as unsigned. The contents are a permutation of what was loaded, so a word with its top bit set sorts above every word with its top bit clear.
- R5: The cycle that samples `start` high in idle is cycle 0. `done` is first high in cycle (k-1)(2k+1)+2s+1, where k=2^L and s is the number of exchanges the algorithm makes. Two words are exchanged only when the outer word is strictly greater, so equal words are never swapped.
- R6: `done` stays high while `start` stays high. It falls one cycle after `start` is seen low, and the engine is then idle again.
- R7: While a sort runs, `host_wr` and `host_rd` are ignored. `host_rdata` stays 0 and the RAM contents are not disturbed.
- R8: Sorting contents that are already in order makes no exchange, so `done` rises at the base latency (k-1)(2k+1)+1.
- R9: During a sort, every write to the outer slot is followed directly by a write to the inner slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_wdata | input | N | Word to store during loading |
| host_addr | input | L | Word address for host writes and reads |
| host_wr | input | 1 | Host write strobe, honoured only when idle |
| start | input | 1 | Starts a sort; must stay high until done |
| host_rd | input | 1 | Host read strobe, honoured only when idle |
| host_rdata | output | N | Read word, one cycle after the strobe, else 0 |
| done | output | 1 | Sort finished; held until start falls |

## Verification
The checker examines the following on every cycle:
- that the output is zero whenever no idle read preceded it,
- that the output stays zero throughout a sort,
- that `done` holds and releases correctly,
- that an exchange begins only when A exceeds B,
- that the two halves of an exchange are written back to back.

The final order, the exact latency that exposes how many exchanges took place, the re-sort of ordered data and the immunity of the stored words to host strobes during a sort can only be shown by the bench's scenarios. These scenarios load each pattern, sort it and read it back.

// File: rtl/xsort_pkg.sv
package xsort_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_I,
        ST_LD_A,
        ST_RD_J,
        ST_LD_B,
        ST_CMP,
        ST_WR_I,
        ST_WR_J,
        ST_STEP,
        ST_FIN
    } xs_state_e;

    // Control bundle from the sequencer to the datapath
    typedef struct packed {
        logic clr_i;
        logic inc_i;
        logic set_j;
        logic inc_j;
        logic ld_a;
        logic ld_b;
        logic a_from_b;
        logic addr_j;
        logic we;
        logic wdat_a;
    } xs_ctrl_t;

    // Status bundle from the datapath to the sequencer
    typedef struct packed {
        logic zi;
        logic zj;
        logic agtb;
    } xs_stat_t;

    function automatic int unsigned base_cycles(input int unsigned k);
        return (k - 1) * (2 * k + 1);
    endfunction

endpackage

// File: rtl/xsort_ram.sv
module xsort_ram #(
    parameter int unsigned N = 8,
    parameter int unsigned L = 3
) (
    input  logic         clk,
    input  logic         we,
    input  logic [L-1:0] addr,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] q
);
    localparam int unsigned DEPTH = 1 << L;

    logic [N-1:0] mem [DEPTH];

    // Single port, synchronous read with one cycle of latency
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        q <= mem[addr];
    end

endmodule

// File: rtl/xsort_datapath.sv
module xsort_datapath
    import xsort_pkg::*;
#(
    parameter int unsigned N = 8,
    parameter int unsigned L = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  xs_ctrl_t     ctl,
    input  logic [N-1:0] ram_q,
    output logic [L-1:0] ram_addr,
    output logic [N-1:0] ram_wdata,
    output xs_stat_t     stat,
    output logic [N-1:0] a_val,
    output logic [N-1:0] b_val
);
    localparam int unsigned K = 1 << L;
    localparam logic [L-1:0] I_LAST = L'(K - 2);
    localparam logic [L-1:0] J_LAST = L'(K - 1);

    logic [L-1:0] idx_i;
    logic [L-1:0] idx_j;
    logic [N-1:0] reg_a;
    logic [N-1:0] reg_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_i <= '0;
        end else if (ctl.clr_i) begin
            idx_i <= '0;
        end else if (ctl.inc_i) begin
            idx_i <= idx_i + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_j <= '0;
        end else if (ctl.set_j) begin
            idx_j <= idx_i + 1'b1;
        end else if (ctl.inc_j) begin
            idx_j <= idx_j + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_a <= '0;
            reg_b <= '0;
        end else begin
            if (ctl.ld_a) begin
                reg_a <= ram_q;
            end else if (ctl.a_from_b) begin
                reg_a <= reg_b;
            end
            if (ctl.ld_b) begin
                reg_b <= ram_q;
            end
        end
    end

    always_comb begin
        ram_addr  = ctl.addr_j ? idx_j : idx_i;
        ram_wdata = ctl.wdat_a ? reg_a : reg_b;
        stat.zi   = (idx_i == I_LAST);
        stat.zj   = (idx_j == J_LAST);
        stat.agtb = (reg_a > reg_b);
    end

    assign a_val = reg_a;
    assign b_val = reg_b;

endmodule

// File: rtl/xsort_ctrl.sv
module xsort_ctrl
    import xsort_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  xs_stat_t  stat,
    output xs_ctrl_t  ctl,
    output xs_state_e state,
    output logic      busy,
    output logic      done
);
    xs_state_e nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        ctl = '0;
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    ctl.clr_i = 1'b1;
                    nxt       = ST_RD_I;
                end
            end
            ST_RD_I: begin
                ctl.set_j = 1'b1;
                nxt       = ST_LD_A;
            end
            ST_LD_A: begin
                ctl.ld_a   = 1'b1;
                ctl.addr_j = 1'b1;
                nxt        = ST_LD_B;
            end
            ST_RD_J: begin
                ctl.addr_j = 1'b1;
                nxt        = ST_LD_B;
            end
            ST_LD_B: begin
                ctl.ld_b = 1'b1;
                nxt      = ST_CMP;
            end
            ST_CMP: begin
                nxt = stat.agtb ? ST_WR_I : ST_STEP;
            end
            ST_WR_I: begin
                ctl.we = 1'b1;
                nxt    = ST_WR_J;
            end
            ST_WR_J: begin
                ctl.we       = 1'b1;
                ctl.addr_j   = 1'b1;
                ctl.wdat_a   = 1'b1;
                ctl.a_from_b = 1'b1;
                nxt          = ST_STEP;
            end
            ST_STEP: begin
                if (stat.zj) begin
                    if (stat.zi) begin
                        nxt = ST_FIN;
                    end else begin
                        ctl.inc_i = 1'b1;
                        nxt       = ST_RD_I;
                    end
                end else begin
                    ctl.inc_j = 1'b1;
                    nxt       = ST_RD_J;
                end
            end
            ST_FIN: begin
                if (!start) begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign busy = (state != ST_IDLE);
    assign done = (state == ST_FIN);

endmodule

// File: rtl/xsort_engine.sv
module xsort_engine
    import xsort_pkg::*;
#(
    parameter int unsigned N = 8,
    parameter int unsigned L = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] host_wdata,
    input  logic [L-1:0] host_addr,
    input  logic         host_wr,
    input  logic         start,
    input  logic         host_rd,
    output logic [N-1:0] host_rdata,
    output logic         done
);
    xs_ctrl_t     ctl;
    xs_stat_t     stat;
    xs_state_e    fsm_state;
    logic         busy;
    logic [L-1:0] dp_addr;
    logic [N-1:0] dp_wdata;
    logic [L-1:0] ram_addr;
    logic [N-1:0] ram_wdata;
    logic [N-1:0] ram_q;
    logic         ram_we;
    logic [N-1:0] a_val;
    logic [N-1:0] b_val;
    logic         rd_vld;

    xsort_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .stat  (stat),
        .ctl   (ctl),
        .state (fsm_state),
        .busy  (busy),
        .done  (done)
    );

    xsort_datapath #(.N(N), .L(L)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .ram_q     (ram_q),
        .ram_addr  (dp_addr),
        .ram_wdata (dp_wdata),
        .stat      (stat),
        .a_val     (a_val),
        .b_val     (b_val)
    );

    // Host owns the RAM port only while idle
    always_comb begin
        ram_addr  = busy ? dp_addr  : host_addr;
        ram_wdata = busy ? dp_wdata : host_wdata;
        ram_we    = busy ? ctl.we   : host_wr;
    end

    xsort_ram #(.N(N), .L(L)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .q     (ram_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_vld <= 1'b0;
        end else begin
            rd_vld <= host_rd && !busy;
        end
    end

    assign host_rdata = rd_vld ? ram_q : '0;

endmodule

// File: rtl/xsort_checker.sv
module xsort_checker
    import xsort_pkg::*;
#(
    parameter int unsigned N = 8,
    parameter int unsigned L = 3
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         host_rd,
    input logic         done,
    input logic [N-1:0] host_rdata,
    input xs_state_e    fsm_state,
    input logic         ram_we,
    input logic [N-1:0] a_val,
    input logic [N-1:0] b_val
);
    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    a_r1_done_low_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !done);

    a_r3_data_zero_without_read: assert property (@(posedge clk) disable iff (rst)
        past_ok && !$past(host_rd) |-> host_rdata == '0);

    a_r7_no_read_while_sorting: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(fsm_state != ST_IDLE) |-> host_rdata == '0);

    a_r5_swap_only_if_greater: assert property (@(posedge clk) disable iff (rst)
        fsm_state == ST_WR_I |-> a_val > b_val);

    a_r9_write_pair: assert property (@(posedge clk) disable iff (rst)
        fsm_state == ST_WR_I |=> fsm_state == ST_WR_J && ram_we);

    a_r6_done_holds: assert property (@(posedge clk) disable iff (rst)
        done && start |=> done);

    a_r6_done_releases: assert property (@(posedge clk) disable iff (rst)
        done && !start |=> !done);

endmodule

bind xsort_engine xsort_checker #(.N(N), .L(L)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .host_rd    (host_rd),
    .done       (done),
    .host_rdata (host_rdata),
    .fsm_state  (fsm_state),
    .ram_we     (ram_we),
    .a_val      (a_val),
    .b_val      (b_val)
);

// File: tb/tb_xsort_engine.sv
module tb_xsort_engine;
    localparam int N = 4;
    localparam int L = 2;
    localparam int K = 1 << L;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] host_wdata = '0;
    logic [L-1:0] host_addr = '0;
    logic         host_wr = 1'b0;
    logic         start = 1'b0;
    logic         host_rd = 1'b0;
    logic [N-1:0] host_rdata;
    logic         done;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    xsort_engine #(.N(N), .L(L)) dut (
        .clk        (clk),
        .rst        (rst),
        .host_wdata (host_wdata),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .start      (start),
        .host_rd    (host_rd),
        .host_rdata (host_rdata),
        .done       (done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_word(input int a, input int v);
        host_addr  = L'(a);
        host_wdata = N'(v);
        host_wr    = 1'b1;
        @(negedge clk);
        host_wr    = 1'b0;
    endtask

    task automatic rd_word(input int a, output int v);
        host_addr = L'(a);
        host_rd   = 1'b1;
        @(negedge clk);
        v       = int'(host_rdata);
        host_rd = 1'b0;
    endtask

    // Exchange sort per the requirement; returns number of exchanges
    function automatic int model_sort(ref int m[K]);
        int s = 0;
        for (int i = 0; i < K - 1; i++) begin
            int a = m[i];
            for (int j = i + 1; j < K; j++) begin
                int b = m[j];
                if (a > b) begin
                    m[i] = b;
                    m[j] = a;
                    a = b;
                    s++;
                end
            end
        end
        return s;
    endfunction

    task automatic run_sort(input int exp_cyc, input bit disturb, input string req);
        int cnt = 0;
        bit seen = 0;
        start = 1'b1;
        while (!seen && cnt < 2000) begin
            @(negedge clk);
            cnt++;
            if (disturb) begin
                chk(host_rdata == '0, "R7", int'(host_rdata), 0);
            end
            if (done) begin
                seen    = 1;
                host_wr = 1'b0;
                host_rd = 1'b0;
            end else if (disturb) begin
                host_wr    = 1'b1;
                host_rd    = 1'b1;
                host_addr  = L'(cnt);
                host_wdata = N'(cnt * 7 + 3);
            end
        end
        chk(cnt == exp_cyc, req, cnt, exp_cyc);
        @(negedge clk);
        chk(done == 1'b1, "R6 hold", int'(done), 1);
        start = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R6 release", int'(done), 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        int vals[4] = '{0, 5, 9, 15};
        int base = (K - 1) * (2 * K + 1) + 1;
        int v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(host_rdata == '0, "R1 rdata", int'(host_rdata), 0);

        for (int p = 0; p < 256; p++) begin
            int m[K];
            int srt[K];
            int s;
            for (int x = 0; x < K; x++) begin
                m[x] = vals[(p >> (2 * x)) & 3];
                srt[x] = m[x];
                wr_word(x, m[x]);
            end
            if (p % 4 == 0) begin
                for (int x = 0; x < K; x++) begin
                    rd_word(x, v);
                    chk(v == m[x], "R2", v, m[x]);
                end
                @(negedge clk);
                chk(host_rdata == '0, "R3 no read", int'(host_rdata), 0);
            end
            s = model_sort(srt);
            run_sort(base + 2 * s, (p % 8 == 3), "R5");
            for (int x = 0; x < K; x++) begin
                rd_word(x, v);
                chk(v == srt[x], (p % 8 == 3) ? "R7 contents" : "R4", v, srt[x]);
            end
            if (p % 16 == 5) begin
                run_sort(base, 1'b0, "R8");
                for (int x = 0; x < K; x++) begin
                    rd_word(x, v);
                    chk(v == srt[x], "R8 contents", v, srt[x]);
                end
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule